// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides whether an incoming frame should be kept, based only on its 48-bit destination address. The address arrives one byte per cycle, first byte first, with a start strobe on the first byte. The block collects the six bytes and, in the same pass, computes the Ethernet CRC-32 of those bytes. One cycle after the sixth byte, it reports an accept decision and a small status word that a receive descriptor can carry.

Four exact-match slots hold full addresses. By convention, slot 0 holds the station's own address and slots 1 to 3 hold multicast groups. A 64-bit hash table, indexed by six bits of the address CRC, can admit multicast groups that do not fit in the slots. A promiscuous control bit admits every frame, and a hash-enable control bit decides whether the table is consulted. Software loads the slots, the four 16-bit hash words and the control word through a simple write port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `result_valid`, `accept` and `rx_status` are all 0, every slot is all zeros, the hash table is clear, and both control bits are off.
- R2: `result_valid` pulses for exactly one cycle, in the cycle after the sixth address byte is taken. `accept` and `rx_status` hold that frame's result until the next result. Bytes with `byte_valid` high but no `byte_start`, after the sixth byte, are ignored until the next `byte_start`.
- R3: Byte k of the address (k = 0 first on the wire) occupies address bits [8k+7:8k]. The low half is bits [15:0], the middle half is [31:16] and the high half is [47:32]. An exact match with a slot accepts the frame, sets `rx_status` bit 2 (0x0004) and puts the slot number in `rx_status[1:0]`.
- R4: When several slots hold the matching address, the lowest slot number is reported.
- R5: A slot holding all zeros never matches, even for an all-zero address.
- R6: The all-ones broadcast address is always accepted, with `rx_status` exactly 0x0020.
- R7: A frame whose first byte has bit 0 set, and which is not broadcast, is multicast and sets `rx_status` bit 4 (0x0010), whether or not it is accepted.
- R8: The hash index is bits [31:26] of a CRC-32 over the 48 address bits. The CRC uses polynomial 0x04C11DB7, takes bits LSB first within each byte, starts from 0xFFFFFFFF and has no final inversion. Index bits [5:4] pick the hash word and bits [3:0] pick the bit in it. If hash enable (control bit 8, 0x0100) is on, the frame is multicast and that bit is 1, the frame is accepted and `rx_status` bit 3 (0x0008) is set.
- R9: With all four hash words at 0xFFFF and hash enable on, every multicast address is accepted. A unicast address that matches no slot is still rejected.
- R10: With the promiscuous bit (control bit 5, 0x0020) on, every frame is accepted. The status flags stay as they would otherwise be.
- R11: Write map on `cfg_addr`. Slot s, half h (0 low, 1 middle, 2 high) is at {1'b0, s[1:0], h[1:0]}. Hash word w is at 0x10+w. The control word is at 0x14. A write takes effect on the next clock edge.
- R12: A frame that is not broadcast, matches no slot, gets no hash hit, and arrives with promiscuous mode off is rejected (`accept` = 0). Its status then has neither the slot-hit bit nor the hash-hit bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | An address byte is present on `byte_data` |
| byte_start | input | 1 | Marks the first byte of a new address (qualified by `byte_valid`) |
| byte_data | input | 8 | Address byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| result_valid | output | 1 | One-cycle pulse when a decision is ready |
| accept | output | 1 | Frame accepted |
| rx_status | output | 16 | Broadcast, multicast, hash-hit and slot-hit flags plus slot index |

## Verification
The bench drives unicast addresses against an empty filter and against a loaded station slot. This separates a real exact match from a default accept, and the all-zero address shows that empty slots stay inert. It sends multicast addresses that are duplicated across slots to expose the slot priority. The broadcast address shows that broadcast overrides the slot and hash flags. For the hash path, the bench computes the CRC index of a chosen group and sets only that table bit, then every bit except that one. Checking with hash enable both on and off pins the word and bit selection and the gating by the enable. Finally, it tries an all-ones table with a unicast address, promiscuous mode, and extra bytes after the sixth one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int          BYTE_W      = 8;
    localparam int          CFG_AW      = 5;
    localparam logic [4:0]  CTRL_ADDR   = 5'h14;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    // status flag positions
    localparam int          ST_BCAST    = 5;
    localparam int          ST_MCAST    = 4;
    localparam int          ST_HASH     = 3;
    localparam int          ST_SLOT     = 2;
    // control word bit positions
    localparam int          CTL_PROMISC = 5;
    localparam int          CTL_HASHEN  = 8;

    // one byte of CRC-32, bits taken LSB first, no reflection of the register
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int N_SLOTS    = 4,
    parameter int HASH_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [15:0]                       cfg_wdata,
    output logic [N_SLOTS-1:0][47:0]          slots,
    output logic [HASH_WORDS-1:0][15:0]       hash_tbl,
    output logic                              promisc,
    output logic                              hash_en
);
    typedef struct packed {
        logic [N_SLOTS-1:0][47:0]    slot;
        logic [HASH_WORDS-1:0][15:0] hash;
        logic                        promisc;
        logic                        hash_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (!cfg_addr[4]) begin
                for (int s = 0; s < N_SLOTS; s++) begin
                    if (cfg_addr[3:2] == 2'(s)) begin
                        case (cfg_addr[1:0])
                            2'd0:    cfg_d.slot[s][15:0]  = cfg_wdata;
                            2'd1:    cfg_d.slot[s][31:16] = cfg_wdata;
                            2'd2:    cfg_d.slot[s][47:32] = cfg_wdata;
                            default: ;
                        endcase
                    end
                end
            end else if (cfg_addr[3:2] == 2'b00) begin
                for (int w = 0; w < HASH_WORDS; w++) begin
                    if (cfg_addr[1:0] == 2'(w)) cfg_d.hash[w] = cfg_wdata;
                end
            end else if (cfg_addr == CTRL_ADDR) begin
                cfg_d.promisc = cfg_wdata[CTL_PROMISC];
                cfg_d.hash_en = cfg_wdata[CTL_HASHEN];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign slots    = cfg_q.slot;
    assign hash_tbl = cfg_q.hash;
    assign promisc  = cfg_q.promisc;
    assign hash_en  = cfg_q.hash_en;

    // R11: a control-word write lands on the next edge
    a_r11_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CTRL_ADDR) |=>
            (promisc == $past(cfg_wdata[CTL_PROMISC]) && hash_en == $past(cfg_wdata[CTL_HASHEN])));
endmodule

// File: rtl/rxf_slot_match.sv
module rxf_slot_match #(
    parameter int N_SLOTS = 4,
    localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [47:0]              addr,
    input  logic [N_SLOTS-1:0][47:0] slots,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);
    logic [N_SLOTS-1:0] match;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign match[s] = (slots[s] != '0) && (slots[s] == addr);
    end

    // lowest-numbered match wins
    always_comb begin
        idx = '0;
        for (int s = N_SLOTS - 1; s >= 0; s--) begin
            if (match[s]) idx = IDX_W'(s);
        end
    end
    assign hit = |match;

    // R5: the reported slot is never an empty one
    a_r5_zero_slot_inert: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slots[idx] != '0));
endmodule

// File: rtl/rxf_hash_lookup.sv
module rxf_hash_lookup #(
    parameter int HASH_WORDS = 4,
    localparam int TBL_BITS  = HASH_WORDS * 16,
    localparam int IDX_W     = $clog2(TBL_BITS)
) (
    input  logic [31:0]         crc,
    input  logic [TBL_BITS-1:0] tbl,
    output logic [IDX_W-1:0]    bin,
    output logic                bit_set
);
    // upper index bits pick the word, low four the bit within it
    assign bin     = crc[31 -: IDX_W];
    assign bit_set = tbl[bin];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int N_SLOTS    = 4,
    parameter int HASH_WORDS = 4,
    parameter int ADDR_BYTES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              byte_start,
    input  logic [7:0]        byte_data,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic              result_valid,
    output logic              accept,
    output logic [15:0]       rx_status
);
    localparam int ADDR_W   = ADDR_BYTES * BYTE_W;
    localparam int CNT_W    = $clog2(ADDR_BYTES + 1);
    localparam int SLOT_IW  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int TBL_BITS = HASH_WORDS * 16;
    localparam int BIN_W    = $clog2(TBL_BITS);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_BYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [31:0]       crc;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              res_valid;
        logic              accept;
        logic [15:0]       status;
    } st_t;

    st_t st_d, st_q;

    logic [N_SLOTS-1:0][47:0]    slots;
    logic [HASH_WORDS-1:0][15:0] hash_tbl;
    logic                        promisc, hash_en;
    logic [ADDR_W-1:0]           addr_nx;
    logic [31:0]                 crc_nx;
    logic                        slot_hit, hash_bit;
    logic [SLOT_IW-1:0]          slot_idx;
    logic [BIN_W-1:0]            hash_bin;

    rxf_cfg_regs #(.N_SLOTS(N_SLOTS), .HASH_WORDS(HASH_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slots(slots), .hash_tbl(hash_tbl),
        .promisc(promisc), .hash_en(hash_en)
    );

    rxf_slot_match #(.N_SLOTS(N_SLOTS)) u_match (
        .clk(clk), .rst_n(rst_n), .addr(addr_nx[47:0]), .slots(slots),
        .hit(slot_hit), .idx(slot_idx)
    );

    rxf_hash_lookup #(.HASH_WORDS(HASH_WORDS)) u_hash (
        .crc(crc_nx), .tbl(hash_tbl), .bin(hash_bin), .bit_set(hash_bit)
    );

    logic             take, last, is_bc, is_mc, hash_ok, slot_ok;
    logic [CNT_W-1:0] pos;
    logic [15:0]      stat_nx;

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;

        take = byte_valid && (byte_start || st_q.busy);
        pos  = byte_start ? '0 : st_q.cnt;
        last = take && (pos == LAST_POS);

        addr_nx = st_q.addr;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (pos == CNT_W'(b)) addr_nx[b*BYTE_W +: BYTE_W] = byte_data;
        end
        crc_nx = crc_byte(byte_start ? 32'hFFFF_FFFF : st_q.crc, byte_data);

        is_bc   = &addr_nx;
        is_mc   = addr_nx[0] && !is_bc;
        slot_ok = slot_hit && !is_bc;
        hash_ok = is_mc && hash_en && hash_bit;

        stat_nx = '0;
        if (is_bc) begin
            stat_nx[ST_BCAST] = 1'b1;
        end else begin
            stat_nx[ST_MCAST] = is_mc;
            stat_nx[ST_HASH]  = hash_ok;
            stat_nx[ST_SLOT]  = slot_ok;
            if (slot_ok) stat_nx[SLOT_IW-1:0] = slot_idx;
        end

        if (take) begin
            st_d.addr = addr_nx;
            st_d.crc  = crc_nx;
            st_d.cnt  = pos + 1'b1;
            st_d.busy = !last;
            if (last) begin
                st_d.res_valid = 1'b1;
                st_d.accept    = is_bc || slot_ok || hash_ok || promisc;
                st_d.status    = stat_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_valid = st_q.res_valid;
    assign accept       = st_q.accept;
    assign rx_status    = st_q.status;

    // R2: a result follows a taken byte and lasts one cycle
    a_r2_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(byte_valid));
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R6: broadcast is accepted and carries no other flag
    a_r6_bcast_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && rx_status[ST_BCAST]) |->
            (accept && rx_status[ST_MCAST:ST_SLOT] == '0));
    // R12: a rejected frame reports no hit
    a_r12_reject_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !accept) |-> (!rx_status[ST_SLOT] && !rx_status[ST_HASH]));
endmodule

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid = 1'b0, byte_start = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        result_valid, accept;
    logic [15:0] rx_status;

    always #2 clk = ~clk;   // 250 MHz

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_start(byte_start),
        .byte_data(byte_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .result_valid(result_valid), .accept(accept),
        .rx_status(rx_status)
    );

    int checks = 0, errors = 0;
    logic [16:0] exp_q[$];
    string       tag_q[$];
    logic [47:0] slot_b[4];
    logic [15:0] hash_b[4];
    logic        prom_b = 1'b0, hen_b = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_bin(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            if (c[31] ^ a[k]) c = (c << 1) ^ 32'h04C1_1DB7;
            else              c = c << 1;
        end
        return c[31:26];
    endfunction

    function automatic logic [16:0] ref_result(input logic [47:0] a);
        logic        bc, mc, hit, hh, acc;
        logic [1:0]  idx;
        logic [5:0]  bn;
        logic [15:0] st;
        bc = &a; mc = a[0] && !bc; hit = 1'b0; idx = '0; st = '0;
        for (int s = 3; s >= 0; s--) begin
            if (slot_b[s] != '0 && slot_b[s] == a) begin hit = 1'b1; idx = 2'(s); end
        end
        bn = ref_bin(a);
        hh = mc && hen_b && hash_b[bn[5:4]][bn[3:0]];
        if (bc) st[5] = 1'b1;
        else begin
            st[4] = mc; st[3] = hh;
            if (hit) begin st[2] = 1'b1; st[1:0] = idx; end
        end
        acc = bc || (hit && !bc) || hh || prom_b;
        return {acc, st};
    endfunction

    task automatic cfg_write(input logic [4:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic set_slot(input int s, input logic [47:0] a);
        for (int h = 0; h < 3; h++) cfg_write({1'b0, 2'(s), 2'(h)}, a[16*h +: 16]);
        slot_b[s] = a;
    endtask

    task automatic set_hash(input int w, input logic [15:0] v);
        cfg_write(5'h10 + 5'(w), v);
        hash_b[w] = v;
    endtask

    task automatic set_ctrl(input logic p, input logic h);
        cfg_write(5'h14, (16'(h) << 8) | (16'(p) << 5));
        prom_b = p; hen_b = h;
    endtask

    task automatic send(input logic [47:0] a, input string tag);
        exp_q.push_back(ref_result(a));
        tag_q.push_back(tag);
        for (int j = 0; j < 6; j++) begin
            @(posedge clk); #1;
            byte_valid = 1'b1; byte_start = (j == 0); byte_data = a[8*j +: 8];
        end
        @(posedge clk); #1;
        byte_valid = 1'b0; byte_start = 1'b0;
        @(negedge clk);
        chk({tag, " R2 result_valid one cycle after byte 6"}, 32'(result_valid), 32'd1);
        @(negedge clk);
        chk("R2 result_valid is a single pulse", 32'(result_valid), 32'd0);
    endtask

    // monitor: pop the expected item as each result appears
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected result_valid", 32'd1, 32'd0);
            end else begin
                logic [16:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 32'({accept, rx_status}), 32'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog expired", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [47:0] STA  = 48'h5544_3322_1100;
    localparam logic [47:0] MC1  = 48'hAA00_5E00_0001;
    localparam logic [47:0] MC2  = 48'h6655_4433_2201;
    localparam logic [47:0] MC3  = 48'h1234_5678_9A03;
    localparam logic [47:0] UNI  = 48'h0BAD_F00D_CA02;

    initial begin
        logic [5:0] bn;
        for (int i = 0; i < 4; i++) begin slot_b[i] = '0; hash_b[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset result_valid", 32'(result_valid), 32'd0);
        chk("R1 reset accept", 32'(accept), 32'd0);
        chk("R1 reset status", 32'(rx_status), 32'd0);
        #1 rst_n = 1'b1;

        send(STA, "R12 unicast with empty filter rejected");
        send(48'h0, "R5 zero address never matches empty slots");

        set_slot(0, STA);
        send(STA, "R3 station slot hit, status 0x0004 index 0");
        send(UNI, "R12 other unicast rejected");

        set_slot(2, MC1);
        send(MC1, "R7 multicast in slot 2, status 0x0016");
        set_slot(3, STA);
        send(STA, "R4 duplicate in slots 0 and 3 reports 0");
        set_slot(1, MC1);
        send(MC1, "R4 duplicate in slots 1 and 2 reports 1");

        send(48'hFFFF_FFFF_FFFF, "R6 broadcast status 0x0020");

        bn = ref_bin(MC2);
        set_hash(int'(bn[5:4]), 16'(1) << bn[3:0]);
        send(MC2, "R8 hash bit set but hash disabled, status 0x0010");
        set_ctrl(1'b0, 1'b1);
        send(MC2, "R8 hash hit with enable, status 0x0018");
        set_hash(int'(bn[5:4]), ~(16'(1) << bn[3:0]));
        send(MC2, "R8 every bit but the indexed one, rejected");

        for (int w = 0; w < 4; w++) set_hash(w, 16'hFFFF);
        send(MC3, "R9 all-ones table accepts multicast");
        send(MC2, "R9 all-ones table accepts second multicast");
        send(UNI, "R9 all-ones table ignores unicast");

        set_ctrl(1'b1, 1'b0);
        send(UNI, "R10 promiscuous accepts unicast");
        send(MC3, "R10 promiscuous keeps multicast flag");
        set_ctrl(1'b0, 1'b0);

        // R2: extra bytes after the sixth are ignored
        send(STA, "R2 frame before stray bytes");
        for (int j = 0; j < 3; j++) begin
            @(posedge clk); #1;
            byte_valid = 1'b1; byte_start = 1'b0; byte_data = 8'hFF;
        end
        @(posedge clk); #1 byte_valid = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R2 stray bytes give no result", 32'(result_valid), 32'd0);
        end
        chk("R2 held accept after stray bytes", 32'(accept), 32'd1);
        chk("R2 held status after stray bytes", 32'(rx_status), 32'h0004);
        send(UNI, "R2 next frame after stray bytes");

        repeat (4) @(posedge clk);
        chk("R2 all expected results seen", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule